// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave side of a 128-byte serial memory that sits on a two-wire bus with an open-drain data line. It samples the clock and data pins into the system clock and detects start and stop conditions. It takes in a control byte, checks the device code, and answers either a write that sets the word address or a read that returns data from its internal array.

A persistent address pointer survives between transactions. A read with no preceding address write returns the byte after the last one transferred. A short write that carries only a word address, followed by a repeated start and a read control byte, gives a random read. If the master acknowledges a data byte, the next byte follows, so one transaction can walk the whole array and wrap around. The array fills itself after reset with each byte equal to its own address. Writes of data into the array are not part of this block.

The data output `sda_pull_o` means "pull the line low". The board or bench ANDs the master's drive with its inverse to form the wired line.

Top module: `twowire_mem_reader`

## Requirements
- R1: While reset is high and until the 128-entry array fill has completed (128 clocks after reset falls), the slave leaves SDA released and ignores the bus.
- R2: The slave acknowledges a control byte only when bits 7..4 equal 4'b1010; bits 3..1 are ignored. On any other code it gives no acknowledge, keeps SDA released and waits for the next start.
- R3: A control byte with bit 0 = 0 is acknowledged, and the next byte is taken as a word address. Its low 7 bits are loaded into the pointer, the byte is acknowledged, and the array contents are left unchanged.
- R4: A control byte with bit 0 = 1 is acknowledged, and then the byte at the pointer is shifted out most significant bit first, one bit per SCL period.
- R5: The pointer holds the address of the last transferred byte plus one, so a read with no address write returns the byte after the previous one.
- R6: A master acknowledge (SDA low at the ninth SCL high) after a data byte makes the slave send the next byte. A no-acknowledge ends the transfer with SDA released.
- R7: The pointer increments by one after each byte sent and wraps from 7Fh to 00h.
- R8: A start or stop condition aborts a byte in progress, and a partially received word address does not change the pointer.
- R9: After reset the array holds, at each address, a byte equal to that address.
- R10: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock pin, asynchronous |
| sda_i | input | 1 | Bus data pin (wired line), asynchronous |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
The hardest situation to reach is a byte broken off halfway. The master has to place a stop or a repeated start after only a few address bits, and then show through a later read that the pointer kept its old value. The bench's master tasks can stop after any number of bits, so it builds these cut-short writes on purpose. A sequential read that starts at 7Dh exercises the wrap. Random reads with random lengths, device sub-bits and a mix of current-address reads then follow a pointer model kept inside the bench.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twr_state_e;
endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_sh[STAGES-1];
      sda_d <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/twr_mem_array.sv
module twr_mem_array #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          ready
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   fill_cnt;

  assign ready = fill_cnt[AW];

  always_ff @(posedge clk) begin
    if (rst) fill_cnt <= '0;
    else if (!ready) fill_cnt <= fill_cnt + 1'b1;
  end

  // single write port used only by the post-reset fill, plus a registered read
  always_ff @(posedge clk) begin
    if (!ready) mem[fill_cnt[AW-1:0]] <= DW'(fill_cnt[AW-1:0]);
    rdata <= mem[raddr];
  end

  // R9: once the fill is done it stays done until the next reset
  a_r9_ready_holds: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
endmodule

// File: rtl/twowire_mem_reader.sv
module twowire_mem_reader #(
  parameter int         ADDR_W      = 7,
  parameter int         DATA_W      = 8,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  import twr_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic mem_ready;
  logic [DATA_W-1:0] rdata;

  twr_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic              kind_addr, rd_mode, more;
  logic [ADDR_W-1:0] ptr;
  logic              pull;

  twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twr_mem_array #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .raddr(ptr), .rdata(rdata), .ready(mem_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      kind_addr <= 1'b0;
      rd_mode   <= 1'b0;
      more      <= 1'b0;
      ptr       <= '0;
      pull      <= 1'b0;
    end else if (start_det && mem_ready) begin
      st        <= ST_RX;
      kind_addr <= 1'b0;
      cnt       <= '0;
      pull      <= 1'b0;
    end else if (stop_det) begin
      st   <= ST_IDLE;
      pull <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && cnt != FULL) begin
            rx_sh <= {rx_sh[DATA_W-2:0], sda_q};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            if (kind_addr) begin
              ptr  <= rx_sh[ADDR_W-1:0];
              pull <= 1'b1;
              st   <= ST_ACK;
            end else if (rx_sh[7:4] == DEV_CODE) begin
              rd_mode <= rx_sh[0];
              pull    <= 1'b1;
              st      <= ST_ACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            pull <= 1'b0;
            cnt  <= '0;
            if (kind_addr) begin
              st <= ST_IDLE;
            end else if (rd_mode) begin
              st    <= ST_TX;
              tx_sh <= {rdata[DATA_W-2:0], 1'b0};
              pull  <= ~rdata[DATA_W-1];
              cnt   <= CNT_W'(1);
            end else begin
              st        <= ST_RX;
              kind_addr <= 1'b1;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == FULL) begin
              pull <= 1'b0;
              ptr  <= ptr + 1'b1;
              st   <= ST_MACK;
            end else begin
              pull  <= ~tx_sh[DATA_W-1];
              tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
              cnt   <= cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            more <= ~sda_q;
          end else if (scl_fall) begin
            if (more) begin
              st    <= ST_TX;
              tx_sh <= {rdata[DATA_W-2:0], 1'b0};
              pull  <= ~rdata[DATA_W-1];
              cnt   <= CNT_W'(1);
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull;

  // R1: no drive before the array is filled
  a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (rst)
    !mem_ready |-> !sda_pull_o);
  // R2: an idle slave never holds the line
  a_r2_idle_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_pull_o);
  // R6: the master's acknowledge slot is left free
  a_r6_mack_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MACK) |-> !sda_pull_o);
  // R7: finishing a sent byte moves the pointer on by one, wrapping
  a_r7_ptr_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MACK && $past(st) == ST_TX) |-> ptr == ADDR_W'($past(ptr) + 1'b1));
  // R10: drive changes only while the clock is low
  a_r10_change_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_q);
endmodule

// File: tb/sim_twowire_mem_reader.sv
module sim_twowire_mem_reader;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic pull;
  wire  sda_line = m_sda & ~pull;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [6:0] exp_ptr = '0;

  always #4 clk = ~clk;

  twowire_mem_reader u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_pull_o(pull)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q / 2);
    b = sda_line; tick(Q - Q / 2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] sub, input logic rd);
    return {4'b1010, sub, rd};
  endfunction

  // random read through an address write and a repeated start
  task automatic rand_read(input logic [6:0] a, input int len, input logic [2:0] sub, input string req);
    logic ak;
    logic [7:0] v;
    bus_start();
    send_byte(ctrl(sub, 1'b0), ak); chk("R2 ctrl write ack", ak, 1);
    send_byte({1'b0, a}, ak);       chk("R3 address ack", ak, 1);
    exp_ptr = a;
    bus_start();
    send_byte(ctrl(sub, 1'b1), ak); chk("R4 ctrl read ack", ak, 1);
    for (int k = 0; k < len; k++) begin
      recv_byte(k != len - 1, v);
      chk(req, v, {1'b0, exp_ptr});
      exp_ptr = exp_ptr + 7'd1;
    end
    bus_stop();
  endtask

  task automatic cur_read(input int len, input logic [2:0] sub, input string req);
    logic ak;
    logic [7:0] v;
    bus_start();
    send_byte(ctrl(sub, 1'b1), ak); chk("R4 ctrl read ack", ak, 1);
    for (int k = 0; k < len; k++) begin
      recv_byte(k != len - 1, v);
      chk(req, v, {1'b0, exp_ptr});
      exp_ptr = exp_ptr + 7'd1;
    end
    bus_stop();
  endtask

  initial begin
    logic ak;
    void'($urandom(32'd2024));
    tick(5);
    chk("R1 released in reset", pull, 0);
    rst = 1'b0;
    tick(20);
    chk("R1 released during fill", pull, 0);
    tick(200);

    // R2: wrong device code is ignored
    bus_start();
    send_byte(8'b1100_0001, ak);
    chk("R2 mismatch no ack", ak, 0);
    chk("R2 line released after mismatch", pull, 0);
    bus_stop();

    // R3 R4 R9: random read at 10h
    rand_read(7'h10, 1, 3'b000, "R4 R9 random read data");
    // R5: current read continues after the last byte
    cur_read(1, 3'b101, "R5 current read data");
    // R6 R7: sequential read across the wrap
    rand_read(7'h7D, 5, 3'b011, "R6 R7 sequential wrap data");
    tick(3 * Q);
    chk("R6 released after nack", pull, 0);
    cur_read(1, 3'b111, "R7 pointer after wrap");

    // R8: stop in the middle of an address byte
    bus_start();
    send_byte(ctrl(3'b000, 1'b0), ak);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    cur_read(1, 3'b000, "R8 stop abort keeps pointer");

    // R8: repeated start in the middle of an address byte
    bus_start();
    send_byte(ctrl(3'b010, 1'b0), ak);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_start();
    send_byte(ctrl(3'b010, 1'b1), ak);
    chk("R8 read ack after restart abort", ak, 1);
    begin
      logic [7:0] v;
      recv_byte(1'b0, v);
      chk("R8 restart abort keeps pointer", v, {1'b0, exp_ptr});
      exp_ptr = exp_ptr + 7'd1;
    end
    bus_stop();

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      int len;
      logic [2:0] sub;
      len = 1 + int'($urandom % 4);
      sub = 3'($urandom % 8);
      if ($urandom % 3 == 0) cur_read(len, sub, "R5 R6 random current read");
      else rand_read(7'($urandom % 128), len, sub, "R4 R6 R7 random read");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule